// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Run-Time Write Policy

This block is a four-line direct-mapped data cache placed between a processor load/store port and a slower word-wide memory port. Every line holds sixteen bytes as four 32-bit words, together with a valid flag, a dirty flag and a tag. Each request carries an 8-bit byte address. For each access the block reports whether it hit and returns the read word. On a miss it refills the whole line from memory before it finishes the request.

A mode input, held steady between resets, picks the store policy. In pass-through mode (`wb_mode` = 0) every store goes to the line and is also written to memory. In deferred mode (`wb_mode` = 1) a store touches only the line and marks it dirty. Memory then sees that data only when the line is replaced. When a dirty line is replaced, its four words are written out before the new line is fetched. A clean line is simply overwritten. Store misses allocate the line in both modes.

Top module: `wpol_cache`

## Requirements
- R1: Address bits [7:6] are the tag, [5:4] the line index, [3:2] the word within the line and [1:0] the byte. A hit needs the indexed line to be valid and its tag to equal bits [7:6]. Lines filled with addresses 0x40, 0xD0 and 0x20 give hit, miss, miss, hit for the sequence 0x48, 0x14, 0x38, 0x10.
- R2: After reset no line is valid, `cpu_ready` is 1, `mem_req` is 0 and `cpu_done` is 0. The first access is therefore a miss.
- R3: A miss reads the four words of the line from memory in ascending order, at byte addresses base+0, +4, +8 and +12. It then returns the addressed word with `cpu_hit` = 0.
- R4: A read hit raises `cpu_done` with `cpu_hit` = 1 one cycle after acceptance, returns the stored word and makes no memory access.
- R5: In pass-through mode a store hit updates the line and performs exactly one memory write of the store word to the word-aligned store address.
- R6: In deferred mode a store hit updates only the line, makes no memory access and completes one cycle after acceptance. Later reads return the new word.
- R7: In deferred mode, replacing a dirty line first writes its four words to memory at the old tag's addresses in ascending order, and only then refills.
- R8: Replacing a clean line, or any line in pass-through mode, makes no memory write.
- R9: A store miss refills the line, then merges the store word. In pass-through mode it also writes that word to memory. In deferred mode it makes no memory write.
- R10: `cpu_ready` is 0 whenever `mem_req` is 1, and it stays 0 from a miss or pass-through store until `cpu_done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1 = deferred (write-back) stores, 0 = pass-through; change only under reset |
| cpu_req | input | 1 | Access request, accepted when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 8 | Byte address |
| cpu_wdata | input | 32 | Store word |
| cpu_ready | output | 1 | Cache idle and accepting a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Access hit, valid with `cpu_done` |
| cpu_rdata | output | 32 | Load word, valid with `cpu_done` |
| mem_req | output | 1 | Memory word transfer request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 8 | Word-aligned byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_ack | input | 1 | One-cycle acknowledge of the current word |
| mem_rdata | input | 32 | Read word, valid with `mem_ack` |

## Verification
The hardest situation to reach is the replacement of a dirty line. That needs deferred mode, a line first filled, then stored to, and then a conflicting tag at the same index. The stimulus resets into deferred mode and fills index 0 with tag 2. It then stores to that line and reads tag 3 at the same index. The memory model logs every write address, so the order of the write-back can be compared against the refill. The store value is then read back through a second conflicting access that misses onto a clean line.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_EVICT  = 3'd1,
        ST_FILL   = 3'd2,
        ST_FINISH = 3'd3,
        ST_THRU   = 3'd4
    } cpc_state_e;
endpackage

// File: rtl/cpc_lookup.sv
module cpc_lookup #(
    parameter int TAG_W = 2,
    parameter int IDX_W = 2,
    localparam int LINES = 1 << IDX_W
) (
    input  logic [LINES-1:0]            line_valid,
    input  logic [LINES-1:0][TAG_W-1:0] line_tag,
    input  logic [IDX_W-1:0]            idx,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit
);
    logic [LINES-1:0] match;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign match[i] = line_valid[i] && (line_tag[i] == tag);
    end

    assign hit = match[idx];
endmodule

// File: rtl/cpc_mem_drive.sv
module cpc_mem_drive
    import cpc_pkg::*;
#(
    parameter int TAG_W  = 2,
    parameter int IDX_W  = 2,
    parameter int WOFF_W = 2,
    parameter int BOFF_W = 2,
    parameter int DATA_W = 32,
    localparam int WA_W  = TAG_W + IDX_W + WOFF_W
) (
    input  cpc_state_e         st,
    input  logic [TAG_W-1:0]   victim_tag,
    input  logic [WA_W-1:0]    req_word_addr,
    input  logic [WOFF_W-1:0]  beat,
    input  logic [DATA_W-1:0]  evict_word,
    input  logic [DATA_W-1:0]  store_word,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WA_W+BOFF_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata
);
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] rtag;
    logic [WA_W-1:0]  wa;

    assign idx  = req_word_addr[WOFF_W +: IDX_W];
    assign rtag = req_word_addr[WA_W-1 -: TAG_W];

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        wa        = req_word_addr;
        mem_wdata = store_word;
        case (st)
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                wa        = {victim_tag, idx, beat};
                mem_wdata = evict_word;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                wa      = {rtag, idx, beat};
            end
            ST_THRU: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr = {wa, {BOFF_W{1'b0}}};
endmodule

// File: rtl/wpol_cache.sv
module wpol_cache
    import cpc_pkg::*;
#(
    parameter int TAG_W  = 2,
    parameter int IDX_W  = 2,
    parameter int WOFF_W = 2,
    parameter int DATA_W = 32,
    localparam int BOFF_W = $clog2(DATA_W / 8),
    localparam int WA_W   = TAG_W + IDX_W + WOFF_W,
    localparam int ADDR_W = WA_W + BOFF_W,
    localparam int LINES  = 1 << IDX_W,
    localparam int WORDS  = 1 << WOFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_mode,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam logic [WOFF_W-1:0] LAST_BEAT = '1;

    typedef struct packed {
        cpc_state_e                                 st;
        logic [LINES-1:0]                           valid;
        logic [LINES-1:0]                           dirty;
        logic [LINES-1:0][TAG_W-1:0]                tag;
        logic [LINES-1:0][WORDS-1:0][DATA_W-1:0]    data;
        logic [WOFF_W-1:0]                          beat;
        logic [WA_W-1:0]                            waddr;
        logic                                       we;
        logic [DATA_W-1:0]                          wdata;
        logic [DATA_W-1:0]                          rdata;
        logic                                       done;
        logic                                       hit;
    } regs_t;

    regs_t q, d;

    logic [LINES-1:0] line_valid;
    logic [LINES-1:0] line_dirty;
    logic             look_hit;
    logic             unused_boff;

    logic [WA_W-1:0]   in_wa;
    logic [TAG_W-1:0]  in_tag;
    logic [IDX_W-1:0]  in_idx;
    logic [WOFF_W-1:0] in_woff;
    logic [IDX_W-1:0]  r_idx;
    logic [TAG_W-1:0]  r_tag;
    logic [WOFF_W-1:0] r_woff;

    assign unused_boff = ^cpu_addr[BOFF_W-1:0];
    assign in_wa       = cpu_addr[ADDR_W-1:BOFF_W];
    assign in_tag      = in_wa[WA_W-1 -: TAG_W];
    assign in_idx      = in_wa[WOFF_W +: IDX_W];
    assign in_woff     = in_wa[WOFF_W-1:0];
    assign r_tag       = q.waddr[WA_W-1 -: TAG_W];
    assign r_idx       = q.waddr[WOFF_W +: IDX_W];
    assign r_woff      = q.waddr[WOFF_W-1:0];
    assign line_valid  = q.valid;
    assign line_dirty  = q.dirty;

    cpc_lookup #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_lookup (
        .line_valid (line_valid),
        .line_tag   (q.tag),
        .idx        (in_idx),
        .tag        (in_tag),
        .hit        (look_hit)
    );

    cpc_mem_drive #(
        .TAG_W(TAG_W), .IDX_W(IDX_W), .WOFF_W(WOFF_W),
        .BOFF_W(BOFF_W), .DATA_W(DATA_W)
    ) u_mem (
        .st            (q.st),
        .victim_tag    (q.tag[r_idx]),
        .req_word_addr (q.waddr),
        .beat          (q.beat),
        .evict_word    (q.data[r_idx][q.beat]),
        .store_word    (q.wdata),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    d.waddr = in_wa;
                    d.we    = cpu_we;
                    d.wdata = cpu_wdata;
                    d.beat  = '0;
                    d.hit   = look_hit;
                    if (look_hit) begin
                        if (!cpu_we) begin
                            d.rdata = q.data[in_idx][in_woff];
                            d.done  = 1'b1;
                        end else begin
                            d.data[in_idx][in_woff] = cpu_wdata;
                            if (wb_mode) begin
                                d.dirty[in_idx] = 1'b1;
                                d.done          = 1'b1;
                            end else begin
                                d.st = ST_THRU;
                            end
                        end
                    end else begin
                        d.st = line_dirty[in_idx] ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                if (mem_ack) begin
                    d.beat = q.beat + 1'b1;
                    if (q.beat == LAST_BEAT) begin
                        d.dirty[r_idx] = 1'b0;
                        d.st           = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    d.data[r_idx][q.beat] = mem_rdata;
                    d.beat                = q.beat + 1'b1;
                    if (q.beat == LAST_BEAT) begin
                        d.tag[r_idx]   = r_tag;
                        d.valid[r_idx] = 1'b1;
                        d.st           = ST_FINISH;
                    end
                end
            end
            ST_FINISH: begin
                if (!q.we) begin
                    d.rdata = q.data[r_idx][r_woff];
                    d.done  = 1'b1;
                    d.st    = ST_IDLE;
                end else begin
                    d.data[r_idx][r_woff] = q.wdata;
                    if (wb_mode) begin
                        d.dirty[r_idx] = 1'b1;
                        d.done         = 1'b1;
                        d.st           = ST_IDLE;
                    end else begin
                        d.st = ST_THRU;
                    end
                end
            end
            ST_THRU: begin
                if (mem_ack) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cpu_ready = (q.st == ST_IDLE);
    assign cpu_done  = q.done;
    assign cpu_hit   = q.hit;
    assign cpu_rdata = q.rdata;
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
    parameter int LINES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wb_mode,
    input logic             cpu_req,
    input logic             cpu_we,
    input logic             cpu_ready,
    input logic             cpu_done,
    input logic             cpu_hit,
    input logic             mem_req,
    input logic             look_hit,
    input logic [LINES-1:0] valid_vec,
    input logic [LINES-1:0] dirty_vec
);
    AST_BUSY_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready); // R10

    AST_THRU_STORE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && cpu_we && !wb_mode) |=> (mem_req && !cpu_ready)); // R5

    AST_WB_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && wb_mode && look_hit) |=> (!mem_req && cpu_done && cpu_hit)); // R6

    AST_MISS_GOES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !look_hit) |=> (mem_req && !cpu_done)); // R3

    AST_DIRTY_ONLY_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dirty_vec & ~$past(dirty_vec))) |-> wb_mode); // R6

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|$past(valid_vec)) |-> ((valid_vec & $past(valid_vec)) == $past(valid_vec))); // R1
endmodule

bind wpol_cache cpc_checker #(.LINES(LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_mode   (wb_mode),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_ready (cpu_ready),
    .cpu_done  (cpu_done),
    .cpu_hit   (cpu_hit),
    .mem_req   (mem_req),
    .look_hit  (look_hit),
    .valid_vec (line_valid),
    .dirty_vec (line_dirty)
);

// File: tb/wpol_cache_test.sv
module wpol_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_mode = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready, cpu_done, cpu_hit;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int r10_viol = 0;

    logic [31:0] bmem [64];
    bit          mem_loaded = 1'b0;
    int          rd_total = 0;
    int          wr_total = 0;
    logic [7:0]  rlog [256];
    logic [7:0]  wlog [256];

    logic        o_hit;
    logic [31:0] o_rdata;
    logic        o_ready_after;
    int          o_rd, o_wr, o_rbase, o_wbase;

    always #5 clk = ~clk;

    wpol_cache uut (
        .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(input int i);
        return 32'hA000_0000 + i;
    endfunction

    always @(posedge clk) begin
        if (!mem_loaded) begin
            for (int i = 0; i < 64; i++) bmem[i] <= init_word(i);
            mem_loaded <= 1'b1;
            mem_ack    <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) bmem[mem_addr[7:2]] <= mem_wdata;
                else        mem_rdata <= bmem[mem_addr[7:2]];
            end
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    wlog[wr_total[7:0]] <= mem_addr;
                    wr_total <= wr_total + 1;
                end else begin
                    rlog[rd_total[7:0]] <= mem_addr;
                    rd_total <= rd_total + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && mem_req && cpu_ready) r10_viol <= r10_viol + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n   = 1'b0;
        wb_mode = mode;
        cpu_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic access(input logic we, input logic [7:0] addr, input logic [31:0] wd);
        int n;
        o_rbase   = rd_total;
        o_wbase   = wr_total;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = addr;
        cpu_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        cpu_req       = 1'b0;
        o_ready_after = cpu_ready;
        n = 0;
        while (!cpu_done && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!cpu_done) begin
            fails++;
            checks++;
            $display("FAIL R10 completion of 0x%02h: actual no done expected done", addr);
        end
        o_hit   = cpu_hit;
        o_rdata = cpu_rdata;
        o_rd    = rd_total - o_rbase;
        o_wr    = wr_total - o_wbase;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        do_reset(1'b0);
        chk("R2", "ready after reset", 32'(cpu_ready), 32'd1);
        chk("R2", "mem_req after reset", 32'(mem_req), 32'd0);
        chk("R2", "done after reset", 32'(cpu_done), 32'd0);
    endtask

    task automatic t_first_miss;
        access(1'b0, 8'h00, '0);
        chk("R2", "first access hit", 32'(o_hit), 32'd0);
        chk("R10", "ready low during refill", 32'(o_ready_after), 32'd0);
        chk("R3", "refill read count", 32'(o_rd), 32'd4);
        for (int i = 0; i < 4; i++)
            chk("R3", "refill read order", 32'(rlog[(o_rbase + i) % 256]), 32'(i * 4));
        chk("R3", "miss read data", o_rdata, init_word(0));
        chk("R8", "clean refill writes", 32'(o_wr), 32'd0);
    endtask

    task automatic t_ref_stream;
        access(1'b0, 8'h40, '0);
        chk("R8", "clean victim writes", 32'(o_wr), 32'd0);
        access(1'b0, 8'hD0, '0);
        access(1'b0, 8'h20, '0);
        access(1'b0, 8'h48, '0);
        chk("R1", "0x48 hit", 32'(o_hit), 32'd1);
        chk("R4", "0x48 data", o_rdata, init_word(8'h48 >> 2));
        chk("R4", "hit ready stays high", 32'(o_ready_after), 32'd1);
        chk("R4", "hit memory reads", 32'(o_rd), 32'd0);
        access(1'b0, 8'h14, '0);
        chk("R1", "0x14 miss", 32'(o_hit), 32'd0);
        chk("R1", "0x14 data", o_rdata, init_word(8'h14 >> 2));
        access(1'b0, 8'h38, '0);
        chk("R1", "0x38 miss", 32'(o_hit), 32'd0);
        chk("R1", "0x38 data", o_rdata, init_word(8'h38 >> 2));
        access(1'b0, 8'h10, '0);
        chk("R1", "0x10 hit", 32'(o_hit), 32'd1);
        chk("R1", "0x10 data", o_rdata, init_word(8'h10 >> 2));
    endtask

    task automatic t_thru_store;
        access(1'b1, 8'h44, 32'h1111_1111);
        chk("R5", "store hit", 32'(o_hit), 32'd1);
        chk("R5", "memory writes", 32'(o_wr), 32'd1);
        chk("R5", "write address", 32'(wlog[o_wbase % 256]), 32'h44);
        chk("R5", "memory word", bmem[8'h44 >> 2], 32'h1111_1111);
        access(1'b0, 8'h44, '0);
        chk("R5", "read back", o_rdata, 32'h1111_1111);
    endtask

    task automatic t_thru_store_miss;
        access(1'b1, 8'hF4, 32'h4444_4444);
        chk("R9", "store miss hit flag", 32'(o_hit), 32'd0);
        chk("R9", "allocate reads", 32'(o_rd), 32'd4);
        chk("R9", "pass-through write", 32'(o_wr), 32'd1);
        chk("R9", "memory word", bmem[8'hF4 >> 2], 32'h4444_4444);
        access(1'b0, 8'hF4, '0);
        chk("R9", "merged word hit", 32'(o_hit), 32'd1);
        chk("R9", "merged word", o_rdata, 32'h4444_4444);
        access(1'b0, 8'hF0, '0);
        chk("R9", "neighbour word", o_rdata, init_word(8'hF0 >> 2));
    endtask

    task automatic t_deferred_store;
        do_reset(1'b1);
        access(1'b0, 8'h80, '0);
        access(1'b1, 8'h84, 32'h2222_2222);
        chk("R6", "store hit", 32'(o_hit), 32'd1);
        chk("R6", "no memory writes", 32'(o_wr), 32'd0);
        chk("R6", "memory unchanged", bmem[8'h84 >> 2], init_word(8'h84 >> 2));
        access(1'b0, 8'h84, '0);
        chk("R6", "read new word", o_rdata, 32'h2222_2222);
    endtask

    task automatic t_dirty_evict;
        access(1'b0, 8'hC0, '0);
        chk("R7", "write-back count", 32'(o_wr), 32'd4);
        for (int i = 0; i < 4; i++)
            chk("R7", "write-back order", 32'(wlog[(o_wbase + i) % 256]), 32'(8'h80 + i * 4));
        chk("R7", "dirty word in memory", bmem[8'h84 >> 2], 32'h2222_2222);
        chk("R7", "refill reads", 32'(o_rd), 32'd4);
        chk("R7", "new line data", o_rdata, init_word(8'hC0 >> 2));
        access(1'b0, 8'h84, '0);
        chk("R8", "clean victim writes", 32'(o_wr), 32'd0);
        chk("R8", "old data from memory", o_rdata, 32'h2222_2222);
    endtask

    task automatic t_deferred_store_miss;
        access(1'b1, 8'h28, 32'h3333_3333);
        chk("R9", "store miss hit flag", 32'(o_hit), 32'd0);
        chk("R9", "allocate reads", 32'(o_rd), 32'd4);
        chk("R9", "deferred no write", 32'(o_wr), 32'd0);
        access(1'b0, 8'h28, '0);
        chk("R9", "merged word", o_rdata, 32'h3333_3333);
        access(1'b0, 8'h2C, '0);
        chk("R9", "neighbour word", o_rdata, init_word(8'h2C >> 2));
    endtask

    initial begin
        t_reset_state();
        t_first_miss();
        t_ref_stream();
        t_thru_store();
        t_thru_store_miss();
        t_deferred_store();
        t_dirty_evict();
        t_deferred_store_miss();
        chk("R10", "ready high while memory busy", 32'(r10_viol), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule